// File: doc/BRIEF.md
# Cascaded ALU slice pair

The block is an 8-bit arithmetic and logic unit built from two copies of a 4-bit slice. Each slice offers sixteen bitwise functions in logic mode and sixteen add-style functions in arithmetic mode, both chosen by a 4-bit select. Data is active-high. The low slice handles bits 3:0 and the high slice handles bits 7:4. The carry ripples from the low slice into the high slice.

Each slice reports four flags: its own carry-out, an all-ones flag on its four result bits, a group propagate and a group generate. These flags are packed into one status byte. A parameter selects an output register. By default the register is present, so the result and the status appear one clock after the inputs.

Inside each slice, two operand terms are formed for every bit:

- X = A | (S0 ? B : 0) | (S1 ? ~B : 0)
- Y = (S3 ? A&B : 0) | (S2 ? A&~B : 0)

Top module: `alu8_slice_pair`

## Requirements
- R1: `ctrl_i` is laid out as {cin at bit 5, M at bit 4, S3..S0 at bits 3:0}. With M=0 the result F is (X + Y + cin) mod 256. By select value this gives:
  - 0: A
  - 1: A|B
  - 2: A|~B
  - 3: all ones
  - 4: A plus (A&~B)
  - 5: (A|B) plus (A&~B)
  - 6: A minus B minus 1
  - 7: (A&~B) minus 1
  - 8: A plus (A&B)
  - 9: A plus B
  - 10: (A|~B) plus (A&B)
  - 11: (A&B) minus 1
  - 12: A plus A
  - 13: (A|B) plus A
  - 14: (A|~B) plus A
  - 15: A minus 1
- R2: With M=1, F = ~(X ^ Y) and cin has no effect on F. By select value this gives:
  - 0: ~A
  - 1: ~(A|B)
  - 2: ~A&B
  - 3: zero
  - 4: ~(A&B)
  - 5: ~B
  - 6: A^B
  - 7: A&~B
  - 8: ~A|B
  - 9: ~(A^B)
  - 10: B
  - 11: A&B
  - 12: all ones
  - 13: A|~B
  - 14: A|B
  - 15: A
- R3: The carry-out of the low slice is the carry-in of the high slice. The high slice carry-out equals bit 8 of X + Y + cin over all 8 bits. This holds in both modes.
- R4: The low slice carry-out equals bit 4 of X[3:0] + Y[3:0] + cin, in both modes.
- R5: A slice's equal flag is 1 exactly when its four F bits are all 1. With M=0, S=6 and cin=0, both equal flags are 1 exactly when A == B.
- R6: A slice's group propagate is the AND of its four X bits. Its group generate is the carry out of its X nibble plus its Y nibble with no carry-in.
- R7: With the output register enabled, F and status change one clock after the inputs. While `rst_ni` is low both outputs are zero.
- R8: `status_o` is packed as {cout_lo, eq_lo, p_lo, g_lo, cout_hi, eq_hi, p_hi, g_hi}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| ctrl_i | input | 6 | Control word {cin, M, S3..S0} |
| f_o | output | 8 | Result F |
| status_o | output | 8 | Packed per-slice flags |

## Verification
The clocked properties assume that A, B and the control word are steady around each sampling edge. The latency property also assumes that the inputs seen in the cycle before an edge are the ones the register captured, which requires reset to have been released for at least one full cycle. The stimulus changes inputs one time unit after a rising edge and holds them until the next edge. It starts only after reset has been released for several cycles. All 64 control words are swept against every value of A and a set of edge-pattern values of B, so every input the block accepts stays inside these assumptions.

// File: rtl/alu_pkg.sv
package alu_pkg;
  parameter int unsigned SEL_W  = 4;
  parameter int unsigned CTRL_W = SEL_W + 2;
  parameter int unsigned FLAG_W = 4;

  typedef struct packed {
    logic             cin;
    logic             logic_mode;
    logic [SEL_W-1:0] sel;
  } alu_ctrl_t;

  typedef struct packed {
    logic cout;
    logic eq;
    logic prop;
    logic gen;
  } slice_flags_t;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             logic_mode_i,
  input  logic             cin_i,
  output logic [W-1:0]     f_o,
  output slice_flags_t     flags_o
);
  logic [W-1:0] x_term, y_term;
  logic [W:0]   carry, gen_acc;

  // y_term is a subset of x_term, so carry = y | (x & c)
  assign x_term = a_i | (b_i & {W{sel_i[0]}}) | (~b_i & {W{sel_i[1]}});
  assign y_term = (a_i & b_i & {W{sel_i[3]}}) | (a_i & ~b_i & {W{sel_i[2]}});

  assign carry[0]   = cin_i;
  assign gen_acc[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry[i+1]   = y_term[i] | (x_term[i] & carry[i]);
    assign gen_acc[i+1] = y_term[i] | (x_term[i] & gen_acc[i]);
  end

  assign f_o = logic_mode_i ? ~(x_term ^ y_term) : (x_term ^ y_term ^ carry[W-1:0]);

  assign flags_o = '{cout: carry[W], eq: &f_o, prop: &x_term, gen: gen_acc[W]};
endmodule

// File: rtl/alu_ripple_core.sv
module alu_ripple_core
  import alu_pkg::*;
#(
  parameter  int unsigned SLICE_W    = 4,
  parameter  int unsigned NUM_SLICES = 2,
  localparam int unsigned DATA_W     = SLICE_W * NUM_SLICES,
  localparam int unsigned STAT_W     = FLAG_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_ctrl_t         ctrl_i,
  output logic [DATA_W-1:0] f_o,
  output logic [STAT_W-1:0] status_o
);
  slice_flags_t flags [NUM_SLICES];

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    logic slice_cin;
    if (k == 0) begin : g_first
      assign slice_cin = ctrl_i.cin;
    end else begin : g_chain
      assign slice_cin = flags[k-1].cout;
    end

    alu_slice #(.W(SLICE_W)) u_slice (
      .a_i          (a_i[k*SLICE_W +: SLICE_W]),
      .b_i          (b_i[k*SLICE_W +: SLICE_W]),
      .sel_i        (ctrl_i.sel),
      .logic_mode_i (ctrl_i.logic_mode),
      .cin_i        (slice_cin),
      .f_o          (f_o[k*SLICE_W +: SLICE_W]),
      .flags_o      (flags[k])
    );

    // low slice lands in the most significant flag group
    assign status_o[(NUM_SLICES-1-k)*FLAG_W +: FLAG_W] = flags[k];
  end
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int unsigned W       = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/alu8_slice_pair.sv
module alu8_slice_pair
  import alu_pkg::*;
#(
  parameter  int unsigned SLICE_W    = 4,
  parameter  int unsigned NUM_SLICES = 2,
  parameter  bit          REG_OUT    = 1'b1,
  localparam int unsigned DATA_W     = SLICE_W * NUM_SLICES,
  localparam int unsigned STAT_W     = FLAG_W * NUM_SLICES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [DATA_W-1:0] f_o,
  output logic [STAT_W-1:0] status_o
);
  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] core_f;
  logic [STAT_W-1:0] core_status;

  assign ctrl = alu_ctrl_t'(ctrl_i);

  alu_ripple_core #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_core (
    .a_i      (a_i),
    .b_i      (b_i),
    .ctrl_i   (ctrl),
    .f_o      (core_f),
    .status_o (core_status)
  );

  alu_out_stage #(.W(DATA_W + STAT_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({core_f, core_status}),
    .q_o    ({f_o, status_o})
  );

  // ---------------- assertions ----------------
  slice_flags_t      lo_flags, hi_flags;
  logic [DATA_W:0]   add_ref;
  logic              all_eq, is_add, past_valid;

  assign lo_flags = core_status[STAT_W-FLAG_W +: FLAG_W];
  assign hi_flags = core_status[0 +: FLAG_W];
  assign add_ref  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, ctrl.cin};
  assign is_add   = !ctrl.logic_mode && (ctrl.sel == 4'd9);

  always_comb begin
    all_eq = 1'b1;
    for (int k = 0; k < NUM_SLICES; k++) all_eq &= core_status[k*FLAG_W + 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  assert_add_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_add |-> ({hi_flags.cout, core_f} == add_ref));

  assert_logic_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.logic_mode && ctrl.sel == 4'd15) |-> (core_f == a_i));

  assert_low_gen_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_flags.gen |-> lo_flags.cout);

  assert_prop_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_flags.prop && ctrl.cin) |-> lo_flags.cout);

  assert_equal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.logic_mode && ctrl.sel == 4'd6 && !ctrl.cin) |-> (all_eq == (a_i == b_i)));

  if (NUM_SLICES > 1) begin : g_ripple_chk
    slice_flags_t next_flags;
    assign next_flags = core_status[STAT_W-2*FLAG_W +: FLAG_W];
    assert_ripple_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lo_flags.cout && next_flags.prop) |-> next_flags.cout);
  end

  if (REG_OUT) begin : g_lat_chk
    assert_reg_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_valid && $past(is_add)) |-> (f_o == $past(add_ref[DATA_W-1:0])));
  end
endmodule

// File: tb/alu8_slice_pair_tb.sv
module alu8_slice_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_r = '0, b_r = '0;
  logic [5:0] ctrl_r = '0;
  logic [7:0] f_w, status_w;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;
  logic [7:0] last_f = '0;

  always #2 clk = ~clk;

  alu8_slice_pair u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .a_i      (a_r),
    .b_i      (b_r),
    .ctrl_i   (ctrl_r),
    .f_o      (f_w),
    .status_o (status_w)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // arithmetic operand pair per select, sum = x + y
  task automatic ref_xy(input logic [7:0] a, input logic [7:0] b, input logic [3:0] s,
                        output logic [7:0] x, output logic [7:0] y);
    case (s)
      4'd0:    begin x = a;        y = 8'h00;   end
      4'd1:    begin x = a | b;    y = 8'h00;   end
      4'd2:    begin x = a | ~b;   y = 8'h00;   end
      4'd3:    begin x = 8'hFF;    y = 8'h00;   end
      4'd4:    begin x = a;        y = a & ~b;  end
      4'd5:    begin x = a | b;    y = a & ~b;  end
      4'd6:    begin x = a | ~b;   y = a & ~b;  end // A + ~B
      4'd7:    begin x = 8'hFF;    y = a & ~b;  end
      4'd8:    begin x = a;        y = a & b;   end
      4'd9:    begin x = a | b;    y = a & b;   end // A + B
      4'd10:   begin x = a | ~b;   y = a & b;   end
      4'd11:   begin x = 8'hFF;    y = a & b;   end
      4'd12:   begin x = a;        y = a;       end
      4'd13:   begin x = a | b;    y = a;       end
      4'd14:   begin x = a | ~b;   y = a;       end
      default: begin x = 8'hFF;    y = a;       end
    endcase
  endtask

  function automatic logic [7:0] ref_logic(input logic [7:0] a, input logic [7:0] b, input logic [3:0] s);
    case (s)
      4'd0:    return ~a;
      4'd1:    return ~(a | b);
      4'd2:    return ~a & b;
      4'd3:    return 8'h00;
      4'd4:    return ~(a & b);
      4'd5:    return ~b;
      4'd6:    return a ^ b;
      4'd7:    return a & ~b;
      4'd8:    return ~a | b;
      4'd9:    return ~(a ^ b);
      4'd10:   return b;
      4'd11:   return a & b;
      4'd12:   return 8'hFF;
      4'd13:   return a | ~b;
      4'd14:   return a | b;
      default: return a;
    endcase
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [5:0] c);
    logic [7:0] x, y, fexp;
    logic [8:0] sum9;
    logic [4:0] lo_c, lo_n, hi_n;
    logic       m, cin, eq0, eq1;
    a_r = a; b_r = b; ctrl_r = c;
    @(posedge clk);
    #1;
    m   = c[4];
    cin = c[5];
    ref_xy(a, b, c[3:0], x, y);
    sum9 = {1'b0, x} + {1'b0, y} + {8'h00, cin};
    lo_c = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'h0, cin};
    lo_n = {1'b0, x[3:0]} + {1'b0, y[3:0]};
    hi_n = {1'b0, x[7:4]} + {1'b0, y[7:4]};
    fexp = m ? ref_logic(a, b, c[3:0]) : sum9[7:0];
    eq0  = &fexp[3:0];
    eq1  = &fexp[7:4];
    chk(m ? "R2" : "R1", "F", f_w, fexp);
    chk("R4", "cout_lo", status_w[7], lo_c[4]);
    chk("R3", "cout_hi", status_w[3], sum9[8]);
    chk("R5", "eq flags", {status_w[6], status_w[2]}, {eq0, eq1});
    chk("R6", "p/g flags", {status_w[5:4], status_w[1:0]},
        {&x[3:0], lo_n[4], &x[7:4], hi_n[4]});
    chk("R8", "status byte", status_w,
        {lo_c[4], eq0, &x[3:0], lo_n[4], sum9[8], eq1, &x[7:4], hi_n[4]});
    last_f = fexp;
  endtask

  initial begin
    logic [7:0] bv [8];
    bv = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h01, 8'h80};
    a_r = 8'h3C; b_r = 8'hC3; ctrl_r = 6'h09;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "reset F", f_w, 0);
    chk("R7", "reset status", status_w, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    for (int c = 0; c < 64; c++)
      for (int bi = 0; bi < 8; bi++)
        for (int a = 0; a < 256; a++)
          apply(8'(a), bv[bi], 6'(c));

    // R5 boundary: equality in subtract-minus-one mode
    apply(8'h5A, 8'h5A, 6'h06);
    chk("R5", "A==B both eq", {status_w[6], status_w[2]}, 2'b11);
    apply(8'h5A, 8'h5B, 6'h06);
    chk("R5", "A!=B not both eq", int'(status_w[6] & status_w[2]), 0);

    // R2: carry-in has no effect in logic mode
    apply(8'h96, 8'h3C, 6'h16);
    chk("R2", "logic xor cin=0", f_w, 8'hAA);
    apply(8'h96, 8'h3C, 6'h36);
    chk("R2", "logic xor cin=1", f_w, 8'hAA);

    // R3: full ripple through both slices
    apply(8'hFF, 8'h00, 6'h29);
    chk("R3", "FF+00+1 F", f_w, 8'h00);
    chk("R3", "FF+00+1 carry", status_w[3], 1);

    // R7: output holds until the next edge
    a_r = 8'h21; b_r = 8'h13; ctrl_r = 6'h09;
    #1;
    chk("R7", "hold before edge", f_w, last_f);
    @(posedge clk);
    #1;
    chk("R7", "update after edge", f_w, 8'h34);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule